// File: doc/BRIEF.md
# Two-Level Page Table Walker

When the translation cache misses, this block resolves a 32-bit logical address into a physical frame number by reading a two-level page table from memory. The requester supplies three values with each walk: the logical address, the physical address of the top-level table, and a count of how many top-level entries exist. The walker splits the address into two table indices and a page offset. It checks the top-level index against the count. It then reads the top-level entry, and from that entry reads the second-level entry. The walk ends with either a frame number or a fault.

The block handles one walk at a time. The requesting side sees a valid/ready handshake for requests and another for responses. The memory side is a read port with one request in flight at a time, returning 32-bit words. Every page-table entry is one 32-bit word. It carries a 20-bit frame number in its upper bits and a valid flag in bit 0. Each table holds 1024 entries and so fills exactly one 4 KB frame.

Top module: `pt_walker2`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and both `resp_valid` and `mem_req_valid` are 0.
- R2: The first memory read is at address {`req_tbl_base`[31:12], `req_vaddr`[31:22], 2'b00}. The low 12 bits of the base are ignored.
- R3: If `req_vaddr`[31:22] is greater than or equal to `req_tbl_len`, the walk ends in a fault and issues no memory read. A length of 0 faults every address, and a length of 1024 admits every index.
- R4: If the top-level entry has bit 0 clear, the walk ends in a fault after exactly one memory read.
- R5: The second memory read is at address {top-level entry[31:12], `req_vaddr`[21:12], 2'b00}. Entry bits 11:1 are ignored.
- R6: If the second-level entry has bit 0 clear, the walk ends in a fault after exactly two reads.
- R7: When both entries are valid, the response has `resp_fault` = 0 and `resp_frame` = second-level entry[31:12].
- R8: Any faulting response presents `resp_frame` = 0.
- R9: A request is accepted only when the walker is idle. While a walk is in progress, `req_ready` is 0 and any `req_valid` is ignored.
- R10: A memory request holds its address stable until `mem_req_ready` accepts it. No further request is issued until the read data has returned.
- R11: A response holds `resp_valid`, `resp_fault` and `resp_frame` steady until `resp_ready` is seen. The walker is ready for a new request in the cycle after that.
- R12: The address, base and length are sampled at acceptance. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Logical address to translate |
| req_tbl_base | input | 32 | Physical address of the top-level table |
| req_tbl_len | input | 11 | Number of top-level entries in use (0..1024) |
| resp_valid | output | 1 | Walk result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_fault | output | 1 | Walk failed (out of range or invalid entry) |
| resp_frame | output | 20 | Physical frame number, 0 on fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | 32 | Entry word read from memory |

## Verification
The bench builds the walker with its default parameters: a 10/10/12 split, 32-bit entries and an 11-bit length field. With these defaults both length extremes, 0 and 1024, can be reached, as can an index exactly at the length and one just below it. The memory model accepts reads after random stalls, returns data after random latency, and puts junk in the ignored entry bits 11:1. The bench also toggles the request inputs during walks and withholds `resp_ready` for random spells. These exercise the stability and sampling rules together with the three fault paths and the success path.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/walk_split.sv
module walk_split #(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  parameter int PG_OFF_W = 12
) (
  input  logic [VA_W-1:0]     vaddr,
  input  logic [L1_IDX_W:0]   tbl_len,
  output logic [L1_IDX_W-1:0] l1_idx,
  output logic [L2_IDX_W-1:0] l2_idx,
  output logic                beyond_len
);

  // upper field indexes the top table, middle field the second table
  assign l1_idx = vaddr[VA_W-1 -: L1_IDX_W];
  assign l2_idx = vaddr[PG_OFF_W +: L2_IDX_W];

  // length counts entries, so an index equal to it is already outside
  assign beyond_len = ({1'b0, l1_idx} >= tbl_len);

  // the page offset plays no part in the walk
  logic unused_offset;
  assign unused_offset = ^vaddr[PG_OFF_W-1:0];

endmodule

// File: rtl/walk_addr.sv
module walk_addr #(
  parameter int PA_W     = 32,
  parameter int PG_OFF_W = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_LG2  = 2
) (
  input  logic [PA_W-PG_OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]         idx,
  output logic [PA_W-1:0]          addr
);

  // bits left between index and frame when a table is smaller than a frame
  localparam int PAD_W = PG_OFF_W - IDX_W - ENT_LG2;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr = {frame, {PAD_W{1'b0}}, idx, {ENT_LG2{1'b0}}};
    end else begin : g_tight
      assign addr = {frame, idx, {ENT_LG2{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int PG_OFF_W = 12,
  parameter int L2_IDX_W = 10,
  parameter int VLD_BIT  = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     acc_beyond,
  input  logic [L2_IDX_W-1:0]      acc_l2_idx,
  input  logic [PA_W-1:0]          l1_addr,
  input  logic [PA_W-1:0]          l2_addr,
  output logic [L2_IDX_W-1:0]      l2_idx_q,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [PA_W-1:0]          mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [PTE_W-1:0]         mem_rsp_data,
  output logic                     resp_valid,
  input  logic                     resp_ready,
  output logic                     resp_fault,
  output logic [PA_W-PG_OFF_W-1:0] resp_frame
);

  localparam int FRM_W = PA_W - PG_OFF_W;

  walk_state_e state;
  logic        ent_ok;
  logic [FRM_W-1:0] ent_frame;

  assign ent_ok    = mem_rsp_data[VLD_BIT];
  assign ent_frame = mem_rsp_data[PG_OFF_W +: FRM_W];
  assign req_ready = (state == ST_IDLE);

  logic unused_pte;
  assign unused_pte = ^mem_rsp_data[PG_OFF_W-1:VLD_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      l2_idx_q      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      resp_valid    <= 1'b0;
      resp_fault    <= 1'b0;
      resp_frame    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            l2_idx_q <= acc_l2_idx;
            if (acc_beyond) begin
              state      <= ST_DONE;
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_frame <= '0;
            end else begin
              state         <= ST_L1_REQ;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= l1_addr;
            end
          end
        end
        ST_L1_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_L1_WAIT;
          end
        end
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_ok) begin
              state      <= ST_DONE;
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_frame <= '0;
            end else begin
              state         <= ST_L2_REQ;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= l2_addr;
            end
          end
        end
        ST_L2_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_L2_WAIT;
          end
        end
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            state      <= ST_DONE;
            resp_valid <= 1'b1;
            resp_fault <= !ent_ok;
            resp_frame <= ent_ok ? ent_frame : '0;
          end
        end
        ST_DONE: begin
          if (resp_ready) begin
            resp_valid <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_OOB_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && acc_beyond) |=> (resp_valid && resp_fault && !mem_req_valid)); // R3

  AST_L1_INVALID_STOP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_L1_WAIT && mem_rsp_valid && !ent_ok) |=> (resp_valid && resp_fault && !mem_req_valid)); // R4

  AST_FAULT_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_frame == '0)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (resp_valid || mem_req_valid) |-> !req_ready); // R9

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R10

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_fault) && $stable(resp_frame))); // R11

endmodule

// File: rtl/pt_walker2.sv
module pt_walker2 #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  parameter int PG_OFF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [PA_W-1:0]          req_tbl_base,
  input  logic [L1_IDX_W:0]        req_tbl_len,
  output logic                     resp_valid,
  input  logic                     resp_ready,
  output logic                     resp_fault,
  output logic [PA_W-PG_OFF_W-1:0] resp_frame,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [PA_W-1:0]          mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [PTE_W-1:0]         mem_rsp_data
);

  localparam int FRM_W   = PA_W - PG_OFF_W;
  localparam int ENT_LG2 = $clog2(PTE_W / 8);

  logic [L1_IDX_W-1:0] l1_idx;
  logic [L2_IDX_W-1:0] l2_idx;
  logic [L2_IDX_W-1:0] l2_idx_q;
  logic                beyond_len;
  logic [PA_W-1:0]     l1_addr;
  logic [PA_W-1:0]     l2_addr;

  logic unused_base_low;
  assign unused_base_low = ^req_tbl_base[PG_OFF_W-1:0];

  walk_split #(
    .VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .PG_OFF_W(PG_OFF_W)
  ) u_split (
    .vaddr(req_vaddr), .tbl_len(req_tbl_len),
    .l1_idx(l1_idx), .l2_idx(l2_idx), .beyond_len(beyond_len)
  );

  // top-level entry address, built from the live inputs at acceptance
  walk_addr #(
    .PA_W(PA_W), .PG_OFF_W(PG_OFF_W), .IDX_W(L1_IDX_W), .ENT_LG2(ENT_LG2)
  ) u_l1_addr (
    .frame(req_tbl_base[PA_W-1:PG_OFF_W]), .idx(l1_idx), .addr(l1_addr)
  );

  // second-level entry address, built straight from the returning top entry
  walk_addr #(
    .PA_W(PA_W), .PG_OFF_W(PG_OFF_W), .IDX_W(L2_IDX_W), .ENT_LG2(ENT_LG2)
  ) u_l2_addr (
    .frame(mem_rsp_data[PG_OFF_W +: FRM_W]), .idx(l2_idx_q), .addr(l2_addr)
  );

  walk_ctrl #(
    .PA_W(PA_W), .PTE_W(PTE_W), .PG_OFF_W(PG_OFF_W), .L2_IDX_W(L2_IDX_W), .VLD_BIT(0)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .acc_beyond(beyond_len), .acc_l2_idx(l2_idx),
    .l1_addr(l1_addr), .l2_addr(l2_addr), .l2_idx_q(l2_idx_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_fault(resp_fault), .resp_frame(resp_frame)
  );

endmodule

// File: tb/pt_walker2_bench.sv
module pt_walker2_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_tbl_base = '0;
  logic [10:0] req_tbl_len = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic        resp_fault;
  logic [19:0] resp_frame;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  pt_walker2 u_pt_walker2 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_tbl_base(req_tbl_base), .req_tbl_len(req_tbl_len),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_fault(resp_fault), .resp_frame(resp_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [31:0] pmem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: random accept stalls, random return latency
  int          nreads = 0;
  logic [31:0] rd_addr [0:3];
  bit          overlap = 0;
  bit          busy = 0;
  int          lat = 0;
  logic [31:0] pend = '0;

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (busy) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend);
          busy = 0;
        end else begin
          lat--;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && busy) overlap = 1;
      if (mem_req_valid && mem_req_ready && !rst) begin
        if (nreads < 4) rd_addr[nreads] = mem_req_addr;
        nreads++;
        pend = mem_req_addr;
        busy = 1;
        lat  = $urandom % 3;
      end
    end
  end

  // reference walk computed from the requirements
  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                          input logic [10:0] len, output bit flt,
                          output logic [19:0] frm, output int nrd,
                          output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] e1, e2;
    flt = 1; frm = '0; nrd = 0; a0 = '0; a1 = '0;
    if ({1'b0, va[31:22]} >= len) return;
    a0 = {base[31:12], va[31:22], 2'b00};
    e1 = rd(a0); nrd = 1;
    if (!e1[0]) return;
    a1 = {e1[31:12], va[21:12], 2'b00};
    e2 = rd(a1); nrd = 2;
    if (!e2[0]) return;
    flt = 0; frm = e2[31:12];
  endtask

  // writes both entries on the path of va, junk in ignored bits 11:1
  task automatic plant(input logic [31:0] va, input logic [31:0] base,
                       input bit v1, input logic [19:0] l2tbl,
                       input bit v2, input logic [19:0] frame);
    logic [31:0] a0, a1;
    logic [10:0] junk1, junk2;
    junk1 = 11'($urandom); junk2 = 11'($urandom);
    a0 = {base[31:12], va[31:22], 2'b00};
    pmem[a0] = {l2tbl, junk1, v1};
    a1 = {l2tbl, va[21:12], 2'b00};
    pmem[a1] = {frame, junk2, v2};
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [10:0] len);
    bit          e_flt;
    logic [19:0] e_frm;
    int          e_nrd;
    logic [31:0] e_a0, e_a1;
    bit          busy_ready_seen;
    logic        h_fault;
    logic [19:0] h_frame;
    bit          stable_ok;
    int          hold;
    string       ftag;

    ref_walk(va, base, len, e_flt, e_frm, e_nrd, e_a0, e_a1);
    ftag = (e_nrd == 0) ? "R3" : (e_nrd == 1) ? "R4" : e_flt ? "R6" : "R7";

    while (!req_ready) @(negedge clk);
    nreads = 0; overlap = 0;
    req_valid = 1'b1; req_vaddr = va; req_tbl_base = base; req_tbl_len = len;
    @(negedge clk);
    // R12: scramble inputs after acceptance; R9: extra requests while busy
    busy_ready_seen = 0;
    while (!resp_valid) begin
      if (req_ready) busy_ready_seen = 1;
      req_valid    = 1'($urandom);
      req_vaddr    = $urandom;
      req_tbl_base = $urandom;
      req_tbl_len  = 11'($urandom);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(!busy_ready_seen && !req_ready, "R9", "ready during walk", 32'(busy_ready_seen), 32'd0);
    chk(resp_fault == e_flt, ftag, "fault", 32'(resp_fault), 32'(e_flt));
    chk(resp_frame == e_frm, e_flt ? "R8" : "R7", "frame", 32'(resp_frame), 32'(e_frm));
    chk(nreads == e_nrd, ftag, "read count", 32'(nreads), 32'(e_nrd));
    if (e_nrd >= 1 && nreads >= 1)
      chk(rd_addr[0] == e_a0, "R2", "first read addr R12", rd_addr[0], e_a0);
    if (e_nrd >= 2 && nreads >= 2)
      chk(rd_addr[1] == e_a1, "R5", "second read addr", rd_addr[1], e_a1);
    chk(!overlap, "R10", "request while read pending", 32'(overlap), 32'd0);

    h_fault = resp_fault; h_frame = resp_frame; stable_ok = 1;
    hold = $urandom % 3;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!resp_valid || resp_fault != h_fault || resp_frame != h_frame) stable_ok = 0;
    end
    chk(stable_ok, "R11", "response held", 32'(stable_ok), 32'd1);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, "R11", "release to idle",
        {30'd0, resp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, base;
    logic [10:0] len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !resp_valid && !mem_req_valid, "R1", "reset outputs",
        {29'd0, req_ready, resp_valid, mem_req_valid}, 32'h4);

    base = 32'h0012_3ABC;
    // R3: zero length faults everything
    walk(32'h0000_0000, base, 11'd0);
    // R3: index equal to length faults, one below passes
    va = {10'd5, 10'd77, 12'h123};
    plant(va, base, 1, 20'h0A5A5, 1, 20'h12345);
    walk(va, base, 11'd5);
    va = {10'd4, 10'd77, 12'h123};
    plant(va, base, 1, 20'h0A5A5, 1, 20'h12345);
    walk(va, base, 11'd5);
    // R3: full length admits top index
    va = {10'd1023, 10'd1023, 12'hFFF};
    plant(va, base, 1, 20'hFFFFE, 1, 20'hFFFFF);
    walk(va, base, 11'd1024);
    // R4: invalid top entry
    va = {10'd9, 10'd3, 12'h0};
    plant(va, base, 0, 20'h00777, 1, 20'h00001);
    walk(va, base, 11'd1024);
    // R6: invalid second entry
    va = {10'd10, 10'd0, 12'h0};
    plant(va, base, 1, 20'h00778, 0, 20'hABCDE);
    walk(va, base, 11'd1024);
    // R7: all-zero frame on valid path
    va = {10'd11, 10'd512, 12'h0};
    plant(va, base, 1, 20'h00000, 1, 20'h00000);
    walk(va, base, 11'd12);

    for (int n = 0; n < 300; n++) begin
      va   = $urandom;
      base = $urandom;
      case ($urandom % 4)
        0: len = 11'd1024;
        1: len = 11'($urandom % 1025);
        2: len = {1'b0, va[31:22]};
        default: len = 11'({1'b0, va[31:22]} + 11'd1);
      endcase
      plant(va, base, ($urandom % 4) != 0, 20'($urandom),
            ($urandom % 4) != 0, 20'($urandom));
      walk(va, base, len);
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule